// File: doc/BRIEF.md
# Two-Digit Quotient Estimator (128-bit by 64-bit)

This block produces a 64-bit estimate of an unsigned quotient whose dividend spans two 64-bit words (upper and lower) and whose divisor is one 64-bit word. It is sized for the significand-divide stage of a floating-point unit. The estimate never falls below the true quotient and overshoots it by at most two.

The estimate is built in two 32-bit digits. Each digit comes from a partial dividend divided by the top 32 bits of the divisor. After the upper digit, the block multiplies the divisor by that digit and subtracts the product from the dividend. A bounded add-back loop then repairs any overestimate. The second digit is drawn from the repaired remainder. A single sequential 64-by-32 digit divider serves both digits.

The controller has six states. `ST_IDLE` waits for `start`. `ST_HI_DIV` waits for the upper digit. `ST_MUL_SUB` forms the remainder. `ST_FIX` runs the add-back loop. `ST_LO_DIV` waits for the lower digit. `ST_FINISH` raises `done` for one cycle.

The transitions are:
- `ST_IDLE`→`ST_FINISH` when `dividend_hi >= divisor` (saturation).
- `ST_IDLE`→`ST_HI_DIV` on any other start.
- `ST_HI_DIV`→`ST_MUL_SUB` when the digit divider reports completion.
- `ST_MUL_SUB`→`ST_FIX` always.
- `ST_FIX`→`ST_FIX` while the remainder is negative and the loop limit is not reached.
- `ST_FIX`→`ST_LO_DIV` otherwise.
- `ST_LO_DIV`→`ST_FINISH` when the digit divider reports completion.
- `ST_FINISH`→`ST_IDLE` always.

Top module: `qest_div128`

## Requirements
- R1: When `start` is taken with `dividend_hi >= divisor`, `quotient` becomes 0xFFFF_FFFF_FFFF_FFFF and `done` is high in the first cycle after the start edge.
- R2: When the divisor's top 32 bits, shifted up by 32, do not exceed `dividend_hi`, the upper digit (quotient bits 63:32) is 0xFFFF_FFFF before correction.
- R3: When the divisor's top 32 bits, shifted up by 32, do not exceed the second partial dividend, the lower digit (bits 31:0) is 0xFFFF_FFFF. The second partial dividend is remainder bits 95:32.
- R4: For a divisor with bit 63 set and `dividend_hi < divisor`, the result lies between the true quotient and the true quotient plus 2, both inclusive.
- R5: `busy` is high from the cycle after an accepted start through the `done` cycle. A `start` seen while `busy` is high is ignored and yields no extra result.
- R6: `done` is a single-cycle pulse. `quotient` holds its value after the pulse until the next result.
- R7: The add-back loop runs at most FIX_LIMIT (default 2) times, and a non-negative remainder remains for a divisor with bit 63 set. A full operation completes within 74 cycles of the start edge.
- R8: The result equals the two-digit estimate exactly. That estimate is: upper digit from division by the divisor's top half, subtract divisor×digit×2^32, add back divisor×2^32 while negative (lowering the digit by one each time), then the lower digit from remainder bits 95:32 divided by the top half.
- R9: A divisor whose top 32 bits are zero does not hang the block: `done` still arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| dividend_hi | input | 64 | Upper word of the dividend |
| dividend_lo | input | 64 | Lower word of the dividend |
| divisor | input | 64 | Divisor, expected with bit 63 set |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result pulse |
| quotient | output | 64 | Quotient estimate, held between results |

## Verification
Random normalised divisors paired with random dividends below them exercise the usual path. Those results are compared both to an independent digit-by-digit model and to the exact 128-bit quotient, which separates a wrong digit from a wrong correction count. Dividends equal to the divisor minus one, and divisors whose lower half exceeds the matching dividend bits, force the upper-digit and lower-digit saturation paths. Dividends at or above the divisor check the immediate all-ones result. A divisor with an empty upper half, plus start pulses raised while busy, test that the block always finishes and emits exactly one result per accepted start.

// File: rtl/qest_pkg.sv
package qest_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HI_DIV,
        ST_MUL_SUB,
        ST_FIX,
        ST_LO_DIV,
        ST_FINISH
    } qest_state_t;
endpackage

// File: rtl/qest_digit_div.sv
module qest_digit_div #(
    parameter int HW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [2*HW-1:0] num,
    input  logic [HW-1:0] den,
    output logic          done,
    output logic [HW-1:0] quo
);
    localparam int CW = $clog2(HW + 1);

    logic [HW-1:0] part, low, q;
    logic [CW-1:0] cnt;
    logic          run, done_r;

    logic [HW:0] trial, diff;
    logic        fits;

    always_comb begin
        trial = {part, low[HW-1]};
        fits  = trial >= {1'b0, den};
        diff  = trial - {1'b0, den};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            part   <= '0;
            low    <= '0;
            q      <= '0;
            cnt    <= '0;
            run    <= 1'b0;
            done_r <= 1'b0;
        end else begin
            done_r <= 1'b0;
            if (go) begin
                if (num[2*HW-1:HW] >= den) begin
                    q      <= '1;
                    run    <= 1'b0;
                    done_r <= 1'b1;
                end else begin
                    part <= num[2*HW-1:HW];
                    low  <= num[HW-1:0];
                    q    <= '0;
                    cnt  <= CW'(HW);
                    run  <= 1'b1;
                end
            end else if (run) begin
                part <= fits ? diff[HW-1:0] : trial[HW-1:0];
                low  <= {low[HW-2:0], 1'b0};
                q    <= {q[HW-2:0], fits};
                cnt  <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    run    <= 1'b0;
                    done_r <= 1'b1;
                end
            end
        end
    end

    assign done = done_r;
    assign quo  = q;

    // R2 / R3: an over-range digit saturates on the next cycle
    assert_digit_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (go && (num[2*HW-1:HW] >= den)) |=> (done && (quo == '1)))
        else $error("digit saturation missing");

    // R6: completion is a single pulse
    assert_digit_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("digit done longer than one cycle");
endmodule

// File: rtl/qest_div128.sv
module qest_div128
    import qest_pkg::*;
#(
    parameter int W         = 64,
    parameter int FIX_LIMIT = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend_hi,
    input  logic [W-1:0] dividend_lo,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int H  = W / 2;
    localparam int FW = $clog2(FIX_LIMIT + 1);

    qest_state_t state, nxt;

    logic [W-1:0]   n_hi, n_lo, dvs, div_num, quo_r;
    logic [H-1:0]   zh, div_q;
    logic [2*W-1:0] rem;
    logic [FW-1:0]  fix_cnt;
    logic           div_go, div_done;

    logic [W+H-1:0] prod;
    logic [2*W-1:0] term, sub_res, addback;
    logic           fix_more;

    qest_digit_div #(.HW(H)) i_digit (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (div_go),
        .num  (div_num),
        .den  (dvs[W-1:H]),
        .done (div_done),
        .quo  (div_q)
    );

    always_comb begin
        prod     = (W+H)'(dvs) * (W+H)'(zh);
        term     = {prod, {H{1'b0}}};
        sub_res  = {n_hi, n_lo} - term;
        addback  = {{H{1'b0}}, dvs, {H{1'b0}}};
        fix_more = rem[2*W-1] && (fix_cnt < FW'(FIX_LIMIT));
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = (dividend_hi >= divisor) ? ST_FINISH : ST_HI_DIV;
            ST_HI_DIV:  if (div_done) nxt = ST_MUL_SUB;
            ST_MUL_SUB: nxt = ST_FIX;
            ST_FIX:     nxt = fix_more ? ST_FIX : ST_LO_DIV;
            ST_LO_DIV:  if (div_done) nxt = ST_FINISH;
            ST_FINISH:  nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_hi    <= '0;
            n_lo    <= '0;
            dvs     <= '0;
            div_num <= '0;
            quo_r   <= '0;
            zh      <= '0;
            rem     <= '0;
            fix_cnt <= '0;
            div_go  <= 1'b0;
        end else begin
            div_go <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    n_hi <= dividend_hi;
                    n_lo <= dividend_lo;
                    dvs  <= divisor;
                    if (dividend_hi >= divisor) begin
                        quo_r <= '1;
                    end else begin
                        div_go  <= 1'b1;
                        div_num <= dividend_hi;
                    end
                end
                ST_HI_DIV: if (div_done) zh <= div_q;
                ST_MUL_SUB: begin
                    rem     <= sub_res;
                    fix_cnt <= '0;
                end
                ST_FIX: if (fix_more) begin
                    zh      <= zh - H'(1);
                    rem     <= rem + addback;
                    fix_cnt <= fix_cnt + FW'(1);
                end else begin
                    div_go  <= 1'b1;
                    div_num <= rem[W+H-1:H];
                end
                ST_LO_DIV: if (div_done) quo_r <= {zh, div_q};
                ST_FINISH: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        busy     = (state != ST_IDLE);
        done     = (state == ST_FINISH);
        quotient = quo_r;
    end

    // R1: dividend word at or above divisor saturates immediately
    assert_full_sat_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && (dividend_hi >= divisor)) |=> (done && (quotient == '1)))
        else $error("full saturation missing");

    // R5: the digit divider reports only while the controller waits for it
    assert_digit_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
        div_done |-> (state == ST_HI_DIV || state == ST_LO_DIV))
        else $error("unexpected digit completion");

    // R6: result pulse lasts one cycle
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done longer than one cycle");

    // R7: for a normalised divisor the correction leaves a non-negative remainder
    assert_fix_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LO_DIV && $past(state) == ST_FIX && dvs[W-1]) |-> !rem[2*W-1])
        else $error("remainder still negative after correction");
endmodule

// File: tb/test_qest_div128.sv
module test_qest_div128;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] dividend_hi = '0, dividend_lo = '0, divisor = '0;
    logic        busy, done;
    logic [63:0] quotient;

    always #4 clk = ~clk;

    qest_div128 i_qest_div128 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dividend_hi(dividend_hi), .dividend_lo(dividend_lo), .divisor(divisor),
        .busy(busy), .done(done), .quotient(quotient)
    );

    typedef struct {
        logic [63:0]  expv;
        logic [127:0] tq;
        int           kind;   // 0 normal, 1 saturate, 2 no-hang only
        int           t0;
        string        tag;
    } item_t;

    item_t sb[$];
    int n_chk = 0, n_fail = 0, cyc = 0;
    logic        prev_done = 1'b0;
    logic [63:0] prev_q = '0;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_est(input logic [63:0] nh, input logic [63:0] nl, input logic [63:0] m);
        logic [127:0] r;
        logic [63:0]  z, mh, pr;
        if (nh >= m) return '1;
        mh = m >> 32;
        if ((mh << 32) <= nh) z = 64'hFFFF_FFFF_0000_0000;
        else                  z = (nh / mh) << 32;
        r = {nh, nl} - (128'(m) * 128'(z));
        for (int i = 0; i < 2; i++) begin
            if (r[127]) begin
                z = z - 64'h1_0000_0000;
                r = r + {32'h0, m, 32'h0};
            end
        end
        pr = r[95:32];
        if ((mh << 32) <= pr) z = z | 64'h0000_0000_FFFF_FFFF;
        else                  z = z | (pr / mh);
        return z;
    endfunction

    task automatic issue(input logic [63:0] nh, input logic [63:0] nl, input logic [63:0] m,
                         input int kind, input string tag);
        item_t it;
        while (busy) @(negedge clk);
        it.expv = ref_est(nh, nl, m);
        it.tq   = {nh, nl} / {64'h0, m};
        it.kind = kind;
        it.t0   = cyc;
        it.tag  = tag;
        sb.push_back(it);
        dividend_hi = nh; dividend_lo = nl; divisor = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R5 busy after start", 128'(busy), 128'(1));
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) begin
                chk(done == 1'b0, "R6 done pulse width", 128'(done), 128'(0));
                chk(quotient == prev_q, "R6 quotient hold", 128'(quotient), 128'(prev_q));
            end
            if (done) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R5 unexpected result", 128'(quotient), 128'(0));
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    if (it.kind == 1) begin
                        chk(quotient == '1, {"R1 ", it.tag}, 128'(quotient), {64'h0, 64'hFFFF_FFFF_FFFF_FFFF});
                        chk(cyc - it.t0 == 1, "R1 latency", 128'(cyc - it.t0), 128'(1));
                    end else if (it.kind == 0) begin
                        chk(quotient == it.expv, {"R8 ", it.tag}, 128'(quotient), 128'(it.expv));
                        chk((128'(quotient) >= it.tq) && (128'(quotient) - it.tq <= 128'(2)),
                            "R4 error bound", 128'(quotient), it.tq);
                        chk(cyc - it.t0 <= 74, "R7 latency", 128'(cyc - it.t0), 128'(74));
                    end else begin
                        chk(1'b1, "R9 completion", 128'(quotient), 128'(quotient));
                    end
                end
            end
            prev_done <= done;
            prev_q    <= quotient;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL R7 watchdog actual=%0d expected<150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] m, h, l;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R5 reset busy", 128'(busy), 128'(0));
        chk(done == 1'b0, "R6 reset done", 128'(done), 128'(0));
        chk(quotient == '0, "R6 reset quotient", 128'(quotient), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R1: saturation at and above the divisor
        issue(64'h8000_0000_0000_0000, 64'h1234, 64'h8000_0000_0000_0000, 1, "equal");
        issue(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h8765_4321_0000_0001, 1, "above");

        // R2: upper digit saturation (divisor top half equals dividend top half)
        issue(64'h8000_0000_0000_0000, 64'h0, 64'h8000_0000_FFFF_FFFF, 0, "R2 upper digit sat");
        issue(64'hC000_0001_0000_0005, 64'hFFFF_0000_1234_5678, 64'hC000_0001_8000_0000, 0, "R2 upper digit sat");

        // R3: dividend just below divisor, low word all ones
        issue(64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R3 lower digit sat");
        issue(64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 0, "R3 lower digit sat");

        // zero dividend, small quotient
        issue(64'h0, 64'h0, 64'h8000_0000_0000_0000, 0, "zero dividend");
        issue(64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 0, "small");

        // R4 / R8: random normalised divisors
        for (int i = 0; i < 300; i++) begin
            m = {1'b1, 31'($urandom), 32'($urandom)};
            h = {32'($urandom), 32'($urandom)};
            l = {32'($urandom), 32'($urandom)};
            if (h >= m) h = h - m;
            if (i % 10 == 3) h = m - 64'd1;
            issue(h, l, m, 0, "random");
        end

        // R5: start pulses while busy are ignored
        issue(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 64'hF000_0000_0000_0001, 0, "R5 first op");
        dividend_hi = 64'h0; dividend_lo = 64'h5; divisor = 64'h8000_0000_0000_0000;
        start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R5 one result per start", 128'(sb.size()), 128'(0));

        // R9: divisor with empty upper half
        issue(64'h0, 64'hDEAD_BEEF_0000_0001, 64'h0000_0000_1234_5678, 2, "R9");
        issue(64'h0000_0000_0000_0010, 64'h0, 64'h0000_0000_0000_0011, 2, "R9");

        while (busy || sb.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R9 all results returned", 128'(sb.size()), 128'(0));
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule